// File: doc/BRIEF.md
# UART Baud Tick Generator with Selectable Prescaler

This block produces the per-bit timing pulse for a serial port from one 32-bit control word. A source selector either takes the system clock divided by four, or takes a crystal reference that enters the clock domain as a one-cycle enable strobe. The crystal strobe passes through a prescaler that can divide it by three, pass it through undivided, or divide it by two. The chosen source strobe then decrements a programmable counter. That counter emits one baud tick every divisor-plus-one source strobes.

Software writes the control word through a simple write port and reads it back combinationally. Every write restarts all prescalers and the baud counter, so the new setting begins on a clean period. No derived clocks exist: every divider is a modulo counter that produces single-cycle enables.

Top module: `baud_tick_gen`

## Requirements
- R1: Control bits 25 and 31:28 are reserved. They read back as 0 and the values written to them are ignored. Writing 0xFFFFFFFF reads back 0x0DFFFFFF.
- R2: While control bit 23 (enable) is 0, `baud_tick` stays low.
- R3: With bit 24 = 0, the source strobe is the system clock divided by 4, so one source strobe occurs every 4 clock cycles.
- R4: With bit 24 = 1, bit 27 = 0 and bit 26 = 0, one source strobe occurs for every 3 crystal strobes.
- R5: With bit 24 = 1, bit 27 = 0 and bit 26 = 1, every crystal strobe is a source strobe.
- R6: With bit 24 = 1 and bit 27 = 1, one source strobe occurs for every 2 crystal strobes, whatever the value of bit 26.
- R7: The divisor D sits in bits 22:0. Consecutive baud ticks are exactly D+1 source strobes apart.
- R8: Each baud tick is a one-cycle pulse whenever the tick period exceeds one clock cycle.
- R9: A write restarts the period. With the crystal strobe high every cycle, the first tick appears on the clock edge P·(D+1) after the write edge, where P is the source period in clock cycles.
- R10: After reset the control word reads 0 and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word, reserved bits zero |
| xtal_stb | input | 1 | Crystal reference enable strobe, one cycle per reference period |
| baud_tick | output | 1 | One-cycle baud tick |

## Verification
A wrong prescaler phase or a wrong selection shows up as a tick spacing that is a wrong multiple of the divisor. The error is visible by the second tick after a write. A counter that fails to reload or restart shows up as a first-tick latency that differs from P·(D+1) edges, so it is caught within one period of the write. A faulty enable or reserved-bit mask shows up at once, in the readback word or as stray ticks.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int DIV_W = 23;

    typedef struct packed {
        logic [3:0]       rsvd_hi;   // 31:28
        logic             half;      // 27 : crystal / 2, overrides bit 26
        logic             direct;    // 26 : crystal undivided
        logic             rsvd_lo;   // 25
        logic             use_xtal;  // 24 : crystal path selected
        logic             enable;    // 23
        logic [DIV_W-1:0] divisor;   // 22:0
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_SYS4   = 2'd0,
        SRC_XTAL3  = 2'd1,
        SRC_XTAL1  = 2'd2,
        SRC_XTAL2  = 2'd3
    } src_sel_e;

    function automatic ctrl_t clean_ctrl(input logic [31:0] raw);
        ctrl_t c;
        c = ctrl_t'(raw);
        c.rsvd_hi = '0;
        c.rsvd_lo = 1'b0;
        return c;
    endfunction

    function automatic src_sel_e pick_source(input ctrl_t c);
        if (!c.use_xtal)   return SRC_SYS4;
        else if (c.half)   return SRC_XTAL2;
        else if (c.direct) return SRC_XTAL1;
        else               return SRC_XTAL3;
    endfunction

endpackage

// File: rtl/bt_prescale.sv
module bt_prescale #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic in_stb,
    output logic out_stb
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    assign out_stb = in_stb && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (in_stb) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bt_src_mux.sv
module bt_src_mux
    import baud_tick_pkg::*;
(
    input  src_sel_e sel,
    input  logic     sys4_stb,
    input  logic     xtal3_stb,
    input  logic     xtal1_stb,
    input  logic     xtal2_stb,
    output logic     src_stb
);
    always_comb begin
        unique case (sel)
            SRC_SYS4:  src_stb = sys4_stb;
            SRC_XTAL3: src_stb = xtal3_stb;
            SRC_XTAL1: src_stb = xtal1_stb;
            SRC_XTAL2: src_stb = xtal2_stb;
            default:   src_stb = 1'b0;
        endcase
    end
endmodule

// File: rtl/bt_down_cnt.sv
module bt_down_cnt #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         run,
    input  logic         stb,
    output logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (load) begin
            cnt  <= load_val;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (run && stb) begin
                if (cnt == '0) begin
                    tick <= 1'b1;
                    cnt  <= reload_val;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int SYS_DIV   = 4,
    parameter int XTAL_SLOW = 3,
    parameter int XTAL_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        xtal_stb,
    output logic        baud_tick
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    src_sel_e         src_sel;
    logic             sys4_stb;
    logic             xtal3_stb;
    logic             xtal2_stb;
    logic             src_stb;
    logic [DIV_W-1:0] cnt_q;

    assign ctrl_new  = clean_ctrl(cfg_wdata);
    assign cfg_rdata = ctrl_q;
    assign src_sel   = pick_source(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_we) begin
            ctrl_q <= ctrl_new;
        end
    end

    bt_prescale #(.N(SYS_DIV)) i_pre_sys (
        .clk(clk), .rst(rst), .clr(cfg_we),
        .in_stb(1'b1), .out_stb(sys4_stb)
    );

    bt_prescale #(.N(XTAL_SLOW)) i_pre_slow (
        .clk(clk), .rst(rst), .clr(cfg_we),
        .in_stb(xtal_stb), .out_stb(xtal3_stb)
    );

    bt_prescale #(.N(XTAL_HALF)) i_pre_half (
        .clk(clk), .rst(rst), .clr(cfg_we),
        .in_stb(xtal_stb), .out_stb(xtal2_stb)
    );

    bt_src_mux i_mux (
        .sel(src_sel),
        .sys4_stb(sys4_stb),
        .xtal3_stb(xtal3_stb),
        .xtal1_stb(xtal_stb),
        .xtal2_stb(xtal2_stb),
        .src_stb(src_stb)
    );

    bt_down_cnt #(.W(DIV_W)) i_cnt (
        .clk(clk),
        .rst(rst),
        .load(cfg_we),
        .load_val(ctrl_new.divisor),
        .reload_val(ctrl_q.divisor),
        .run(ctrl_q.enable),
        .stb(src_stb),
        .tick(baud_tick),
        .cnt(cnt_q)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        baud_tick,
    input logic        src_stb,
    input logic [22:0] cnt_q
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[25] == 1'b0) && (cfg_rdata[31:28] == 4'd0)); // R1

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[23] |-> !baud_tick); // R2

    AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(src_stb)); // R7

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !src_stb) |=> $stable(cnt_q)); // R7

    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cnt_q == $past(cfg_wdata[22:0]))); // R9
endmodule

bind baud_tick_gen baud_tick_gen_chk i_chk (
    .clk(clk),
    .rst(rst),
    .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .baud_tick(baud_tick),
    .src_stb(src_stb),
    .cnt_q(cnt_q)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xtal_stb = 1'b0;
    logic        baud_tick;

    int n_chk  = 0;
    int n_fail = 0;
    int gap    = 1;
    int xg     = 0;

    baud_tick_gen i_baud_tick_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xtal_stb(xtal_stb), .baud_tick(baud_tick)
    );

    always #5 clk = ~clk;

    // crystal strobe: high once every `gap` cycles, changed away from the edge
    always @(negedge clk) begin
        xg = (xg + 1) % gap;
        xtal_stb = (xg == 0);
    end

    typedef struct packed {
        logic [31:0] wdata;
        int          xgap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h0080_0000, 1},   // sys, D=0
        '{32'h0080_0005, 1},   // sys, D=5
        '{32'hF280_0001, 1},   // sys, D=1, reserved bits set
        '{32'h0180_0002, 1},   // crystal /3
        '{32'h0180_0003, 2},   // crystal /3, sparse strobe
        '{32'h0580_0000, 1},   // crystal undivided, D=0
        '{32'h0580_0006, 3},   // crystal undivided, sparse
        '{32'h0980_0004, 1},   // crystal /2
        '{32'h0D80_0004, 1},   // /2 overriding undivided
        '{32'h0D80_0001, 2}    // /2 overriding, sparse
    };

    function automatic int src_period(input logic [31:0] w, input int g);
        if (!w[24])      return 4;
        else if (w[27])  return 2 * g;
        else if (w[26])  return g;
        else             return 3 * g;
    endfunction

    function automatic string src_req(input logic [31:0] w);
        if (!w[24])      return "R3";
        else if (w[27])  return "R6";
        else if (w[26])  return "R5";
        else             return "R4";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // edges counted from the write edge; first and second tick positions
    task automatic meas(input int limit, output int first, output int second);
        first  = -1;
        second = -1;
        for (int c = 1; c <= limit; c++) begin
            @(posedge clk);
            #1;
            if (baud_tick) begin
                if (first < 0) first = c;
                else begin
                    second = c;
                    break;
                end
            end
        end
    endtask

    task automatic count_ticks(input int cycles, output int ticks, output int longest);
        int run;
        ticks = 0; longest = 0; run = 0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            #1;
            if (baud_tick) begin
                ticks++;
                run++;
                if (run > longest) longest = run;
            end else run = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int f, s, per, t, lng;
        logic [31:0] exp_rd;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R10: reset state
        chk(cfg_rdata == 32'd0, "R10 readback", int'(cfg_rdata), 0);
        count_ticks(50, t, lng);
        chk(t == 0, "R10 ticks after reset", t, 0);

        // table walk: source selection, period, restart latency
        foreach (VEC[i]) begin
            gap = VEC[i].xgap;
            wr(VEC[i].wdata);
            exp_rd = VEC[i].wdata & 32'h0DFF_FFFF;
            chk(cfg_rdata == exp_rd, "R1 readback", int'(cfg_rdata), int'(exp_rd));
            per = src_period(VEC[i].wdata, gap) * (int'(VEC[i].wdata[22:0]) + 1);
            meas(3 * per + 20, f, s);
            chk((s - f) == per, src_req(VEC[i].wdata), s - f, per);
            chk((s - f) == per, "R7 period", s - f, per);
            if (gap == 1)
                chk(f == per, "R9 first tick", f, per);
        end
        gap = 1;

        // R1: all-ones write
        wr(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0DFF_FFFF, "R1 all ones", int'(cfg_rdata), int'(32'h0DFF_FFFF));

        // R2: enable clear, nonzero divisor
        wr(32'h0000_0003);
        count_ticks(300, t, lng);
        chk(t == 0, "R2 disabled ticks", t, 0);
        wr(32'h0580_0000);
        repeat (5) @(posedge clk);
        wr(32'h0500_0000);
        count_ticks(100, t, lng);
        chk(t == 0, "R2 stop while running", t, 0);

        // R8: single-cycle pulses, period 12
        wr(32'h0080_0002);
        count_ticks(120, t, lng);
        chk(t == 10, "R8 tick count", t, 10);
        chk(lng == 1, "R8 pulse width", lng, 1);

        // R9: mid-period rewrite restarts the period (period 16)
        wr(32'h0080_0003);
        repeat (10) @(posedge clk);
        wr(32'h0080_0003);
        meas(60, f, s);
        chk(f == 16, "R9 restart first tick", f, 16);
        chk((s - f) == 16, "R9 restart period", s - f, 16);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule